// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the control and status state of one processor strand behind a single indexed port. Software-visible writes arrive on a synchronous write port of index plus data. Reads are combinational on a separate read index. Several registers are not plain storage. The processor-state word keeps only its architected bits, and the trap base drops its low offset bits. The window pointer saturates at the last window. The trap registers are banked per trap level, and the current trap-level register picks the bank implicitly.

The tick register is not a counter of its own. A 64-bit free-running counter advances on an input strobe. A tick write stores the difference between the written value and that counter as an offset, and keeps the top bit apart as a flag. A tick read adds the offset back to the counter. The block also presents a read-only packed status word that collects privilege, address-mask, load/store-unit enables, partition, trap level and both contexts for a memory-management unit. Any access to an index that holds no register is rejected: an error strobe rises, a read returns zero, and no state changes.

Top module: `ctl_regbank`

## Requirements
- R1: Index map (6-bit): 0 tick, 1 floating-point status, 2 processor state, 3 trap base, 4 trap level, 5 window pointer, 6 hypervisor state, 7 strand status, 8 partition id, 9 load/store control, 10 primary context, 11 secondary context, 12 trap PC, 13 trap next-PC, 14 trap state, 15 trap type, 16 hypervisor trap state, 17 packed MMU word, 24..39 sixteen plain slots (scratchpad and queue head/tail). Plain 64-bit registers read back the last value written.
- R2: After reset, tick reads 0x8000_0000_0000_0000, hypervisor state reads 0x800, strand status reads 0x50000, the floating-point status reads 0x3, and every other register reads zero.
- R3: A processor-state write keeps only the bits in mask 0x13DE (bits 12, 9..6, 4..1) and clears the rest.
- R4: A trap-base write clears bits 14..0.
- R5: Indices 12..16 each address an array with MAX_TL entries, and an access uses entry TL-1. The trap-level register (index 4) keeps the low 3 bits of the written value.
- R6: If TL is 0 or above MAX_TL, an access to indices 12..16 raises the error output for that port, reads zero and writes nothing.
- R7: A window-pointer write of NWIN or more stores NWIN-1. A smaller value is stored as written.
- R8: The free-running counter advances once per cycle with cnt_inc high. After a tick write of V, bits 62:2 of a tick read equal bits 62:2 of (V + the number of strobed cycles from the write cycle on, the write cycle included), modulo 2^63.
- R9: A tick read has bits 1:0 at zero and bit 63 equal to bit 63 of the last tick write.
- R10: A floating-point status read always shows bits 1:0 set. The other bits read back as written.
- R11: Index 17 reads {secondary ctx[15:0], primary ctx[15:0], 13'b0, TL[2:0], partition[7:0], 2'b0, ldst ctl[3:2], pstate[3:2], hvstate[5], hvstate[2]} (bit 63 down to bit 0). It is read-only: a write raises wr_err and changes nothing.
- R12: Indices 18..23 and 40..63 are unimplemented. Reading one raises rd_err and returns zero. Writing one raises wr_err and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_inc | input | 1 | Free-running counter advance strobe |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write value |
| wr_err | output | 1 | Write rejected (combinational, with wr_en) |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Combinational read value |
| rd_err | output | 1 | Read index invalid |

## Verification
The assertions assume that wr_idx, rd_idx and wr_data carry known values in every cycle after reset, and that cnt_inc may toggle freely, including in a tick-write cycle. The stimulus holds every input at a defined level from time zero. It limits trap-level writes to 0..7, so banks that are valid and both kinds of invalid level are all reached. It draws write and read indices across the full 6-bit space, so unimplemented holes and the read-only word are hit next to the real registers.

// File: rtl/crf_pkg.sv
package crf_pkg;
    localparam logic [5:0] IDX_TICK    = 6'd0;
    localparam logic [5:0] IDX_FPSTAT  = 6'd1;
    localparam logic [5:0] IDX_PSTATE  = 6'd2;
    localparam logic [5:0] IDX_TBASE   = 6'd3;
    localparam logic [5:0] IDX_TLVL    = 6'd4;
    localparam logic [5:0] IDX_WPTR    = 6'd5;
    localparam logic [5:0] IDX_HVSTATE = 6'd6;
    localparam logic [5:0] IDX_STRAND  = 6'd7;
    localparam logic [5:0] IDX_PARTID  = 6'd8;
    localparam logic [5:0] IDX_LSUCTL  = 6'd9;
    localparam logic [5:0] IDX_PCTX    = 6'd10;
    localparam logic [5:0] IDX_SCTX    = 6'd11;
    localparam logic [5:0] IDX_TPC     = 6'd12;
    localparam logic [5:0] IDX_HTSTATE = 6'd16;
    localparam logic [5:0] IDX_MMU     = 6'd17;
    localparam logic [5:0] SLOT_BASE   = 6'd24;
    localparam logic [5:0] SLOT_END    = 6'd40;
    localparam int         NSLOT       = 16;
    localparam int         SLOT_W      = $clog2(NSLOT);
    localparam int         NTRAPF      = 5;

    localparam logic [63:0] PSTATE_KEEP = 64'h0000_0000_0000_13DE;
    localparam logic [63:0] TBASE_DROP  = 64'h0000_0000_0000_7FFF;
    localparam logic [63:0] HV_RST      = 64'h0000_0000_0000_0800;
    localparam logic [63:0] STRAND_RST  = 64'h0000_0000_0005_0000;
endpackage

// File: rtl/crf_tick_unit.sv
module crf_tick_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inc,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    output logic [63:0] rd_data
);
    logic [63:0] cnt_q;
    logic [63:0] off_q;
    logic        flag_q;
    logic [63:0] sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            off_q  <= '0;
            flag_q <= 1'b1;
        end else begin
            if (inc)
                cnt_q <= cnt_q + 64'd1;
            if (wr_en) begin
                off_q  <= {1'b0, wr_data[62:0]} - cnt_q;
                flag_q <= wr_data[63];
            end
        end
    end

    assign sum     = cnt_q + off_q;
    assign rd_data = {flag_q, sum[62:2], 2'b00};

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> cnt_q == $past(cnt_q) + 64'd1);
    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> cnt_q == $past(cnt_q));
    a_r9_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[63] == $past(wr_data[63]));
endmodule

// File: rtl/crf_trap_stack.sv
module crf_trap_stack #(
    parameter int MAX_TL = 6,
    parameter int NF     = 5,
    parameter int TLW    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TLW-1:0] tl,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [63:0]    wr_data,
    input  logic [2:0]     rd_sel,
    output logic [63:0]    rd_data,
    output logic           lvl_bad
);
    localparam int PW = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;

    logic [TLW-1:0] tl_m1;
    logic [PW-1:0]  ptr;
    logic [63:0]    fld_rd [NF];

    assign tl_m1   = tl - TLW'(1);
    assign ptr     = PW'(tl_m1);
    assign lvl_bad = (tl == '0) || (tl > TLW'(MAX_TL));

    for (genvar f = 0; f < NF; f++) begin : g_field
        logic [63:0] ent [MAX_TL];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < MAX_TL; k++)
                    ent[k] <= '0;
            end else if (wr_en && !lvl_bad && wr_sel == 3'(f)) begin
                ent[ptr] <= wr_data;
            end
        end
        assign fld_rd[f] = ent[ptr];
    end

    always_comb begin
        if (lvl_bad || rd_sel >= 3'(NF))
            rd_data = '0;
        else
            rd_data = fld_rd[rd_sel];
    end

    a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_bad |-> int'(ptr) < MAX_TL);
endmodule

// File: rtl/crf_mmu_pack.sv
module crf_mmu_pack (
    input  logic [63:0] hvstate,
    input  logic [63:0] pstate,
    input  logic [63:0] lsuctl,
    input  logic [63:0] partid,
    input  logic [2:0]  tl3,
    input  logic [63:0] pctx,
    input  logic [63:0] sctx,
    output logic [63:0] word
);
    always_comb begin
        word          = '0;
        word[0]       = hvstate[2];
        word[1]       = hvstate[5];
        word[3:2]     = pstate[3:2];
        word[5:4]     = lsuctl[3:2];
        word[15:8]    = partid[7:0];
        word[18:16]   = tl3;
        word[47:32]   = pctx[15:0];
        word[63:48]   = sctx[15:0];
    end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import crf_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int NWIN   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_inc,
    input  logic        wr_en,
    input  logic [5:0]  wr_idx,
    input  logic [63:0] wr_data,
    output logic        wr_err,
    input  logic [5:0]  rd_idx,
    output logic [63:0] rd_data,
    output logic        rd_err
);
    localparam int TLW  = $clog2(MAX_TL + 1);
    localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1;

    logic [63:0]     fpstat_q, pstate_q, tbase_q, hv_q, strand_q;
    logic [63:0]     partid_q, lsu_q, pctx_q, sctx_q;
    logic [63:0]     slot_q [NSLOT];
    logic [TLW-1:0]  tl_q;
    logic [CWPW-1:0] wptr_q;
    logic [63:0]     tick_rd, trap_rd, mmu_word, rd_raw;
    logic            lvl_bad, wr_ok, wr_trap, rd_trap;
    logic [5:0]      rd_soff, wr_soff;

    function automatic logic is_impl(input logic [5:0] i);
        return (i <= IDX_MMU) || (i >= SLOT_BASE && i < SLOT_END);
    endfunction

    function automatic logic is_trap(input logic [5:0] i);
        return (i >= IDX_TPC) && (i <= IDX_HTSTATE);
    endfunction

    assign wr_trap = is_trap(wr_idx);
    assign rd_trap = is_trap(rd_idx);
    assign wr_err  = wr_en && (!is_impl(wr_idx) || wr_idx == IDX_MMU ||
                               (wr_trap && lvl_bad));
    assign rd_err  = !is_impl(rd_idx) || (rd_trap && lvl_bad);
    assign wr_ok   = wr_en && !wr_err;
    assign rd_soff = rd_idx - SLOT_BASE;
    assign wr_soff = wr_idx - SLOT_BASE;

    crf_tick_unit u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .wr_en   (wr_ok && wr_idx == IDX_TICK),
        .wr_data (wr_data),
        .rd_data (tick_rd)
    );

    crf_trap_stack #(.MAX_TL(MAX_TL), .NF(NTRAPF), .TLW(TLW)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .tl      (tl_q),
        .wr_en   (wr_ok && wr_trap),
        .wr_sel  (3'(wr_idx - IDX_TPC)),
        .wr_data (wr_data),
        .rd_sel  (3'(rd_idx - IDX_TPC)),
        .rd_data (trap_rd),
        .lvl_bad (lvl_bad)
    );

    crf_mmu_pack u_mmu (
        .hvstate (hv_q),
        .pstate  (pstate_q),
        .lsuctl  (lsu_q),
        .partid  (partid_q),
        .tl3     (3'(tl_q)),
        .pctx    (pctx_q),
        .sctx    (sctx_q),
        .word    (mmu_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpstat_q <= '0;
            pstate_q <= '0;
            tbase_q  <= '0;
            hv_q     <= HV_RST;
            strand_q <= STRAND_RST;
            partid_q <= '0;
            lsu_q    <= '0;
            pctx_q   <= '0;
            sctx_q   <= '0;
            tl_q     <= '0;
            wptr_q   <= '0;
        end else if (wr_ok) begin
            case (wr_idx)
                IDX_FPSTAT:  fpstat_q <= wr_data;
                IDX_PSTATE:  pstate_q <= wr_data & PSTATE_KEEP;
                IDX_TBASE:   tbase_q  <= wr_data & ~TBASE_DROP;
                IDX_TLVL:    tl_q     <= wr_data[TLW-1:0];
                IDX_WPTR:    wptr_q   <= (wr_data >= 64'(NWIN)) ? CWPW'(NWIN - 1)
                                                                : wr_data[CWPW-1:0];
                IDX_HVSTATE: hv_q     <= wr_data;
                IDX_STRAND:  strand_q <= wr_data;
                IDX_PARTID:  partid_q <= wr_data;
                IDX_LSUCTL:  lsu_q    <= wr_data;
                IDX_PCTX:    pctx_q   <= wr_data;
                IDX_SCTX:    sctx_q   <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (wr_ok && wr_idx >= SLOT_BASE && wr_soff[SLOT_W-1:0] == SLOT_W'(s))
                slot_q[s] <= wr_data;
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_TICK:    rd_raw = tick_rd;
            IDX_FPSTAT:  rd_raw = fpstat_q | 64'h3;
            IDX_PSTATE:  rd_raw = pstate_q;
            IDX_TBASE:   rd_raw = tbase_q;
            IDX_TLVL:    rd_raw = 64'(tl_q);
            IDX_WPTR:    rd_raw = 64'(wptr_q);
            IDX_HVSTATE: rd_raw = hv_q;
            IDX_STRAND:  rd_raw = strand_q;
            IDX_PARTID:  rd_raw = partid_q;
            IDX_LSUCTL:  rd_raw = lsu_q;
            IDX_PCTX:    rd_raw = pctx_q;
            IDX_SCTX:    rd_raw = sctx_q;
            IDX_MMU:     rd_raw = mmu_word;
            default:     rd_raw = rd_trap ? trap_rd : slot_q[rd_soff[SLOT_W-1:0]];
        endcase
        rd_data = rd_err ? 64'd0 : rd_raw;
    end

    a_r3_pstate_mask: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx == IDX_PSTATE |-> (rd_data & ~PSTATE_KEEP) == 64'd0);
    a_r4_tbase_low: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx == IDX_TBASE |-> rd_data[14:0] == 15'd0);
    a_r7_wptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx == IDX_WPTR |-> rd_data < 64'(NWIN));
    a_r9_tick_low: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx == IDX_TICK |-> rd_data[1:0] == 2'b00);
    a_r10_fp_low: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx == IDX_FPSTAT |-> rd_data[1:0] == 2'b11);
    a_r11_mmu_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_MMU) |-> wr_err);
    a_r12_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_data == 64'd0);
    a_r6_tl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IDX_TLVL) |=> tl_q == $past(tl_q));
endmodule

// File: tb/ctl_regbank_test.sv
module ctl_regbank_test;
    import crf_pkg::*;
    localparam int MAX_TL = 6;
    localparam int NWIN   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_inc = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        rd_err, wr_err;

    int nvec = 0;
    int nbad = 0;

    ctl_regbank #(.MAX_TL(MAX_TL), .NWIN(NWIN)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_inc(cnt_inc), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err)
    );

    always #5 clk = ~clk;

    // expected state, kept from the requirements
    logic [63:0] m_reg  [64];
    logic [63:0] m_trap [NTRAPF][MAX_TL];
    logic [62:0] m_tick;
    logic        m_flag;

    function automatic bit m_lvl_bad();
        return m_reg[4] == 0 || m_reg[4] > MAX_TL;
    endfunction

    function automatic bit m_impl(int i);
        return i <= 17 || (i >= 24 && i <= 39);
    endfunction

    function automatic bit m_trapidx(int i);
        return i >= 12 && i <= 16;
    endfunction

    function automatic bit exp_werr(int i);
        return !m_impl(i) || i == 17 || (m_trapidx(i) && m_lvl_bad());
    endfunction

    function automatic bit exp_rerr(int i);
        return !m_impl(i) || (m_trapidx(i) && m_lvl_bad());
    endfunction

    function automatic logic [63:0] exp_mmu();
        logic [63:0] w = '0;
        w[0]     = m_reg[6][2];
        w[1]     = m_reg[6][5];
        w[3:2]   = m_reg[2][3:2];
        w[5:4]   = m_reg[9][3:2];
        w[15:8]  = m_reg[8][7:0];
        w[18:16] = m_reg[4][2:0];
        w[47:32] = m_reg[10][15:0];
        w[63:48] = m_reg[11][15:0];
        return w;
    endfunction

    function automatic logic [63:0] exp_rd(int i);
        if (exp_rerr(i)) return 64'd0;
        if (i == 0) return {m_flag, m_tick[62:2], 2'b00};
        if (i == 1) return m_reg[1] | 64'h3;
        if (i == 17) return exp_mmu();
        if (m_trapidx(i)) return m_trap[i-12][m_reg[4]-1];
        return m_reg[i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 64; k++) m_reg[k] = '0;
            for (int f = 0; f < NTRAPF; f++)
                for (int k = 0; k < MAX_TL; k++) m_trap[f][k] = '0;
            m_reg[6] = 64'h800;
            m_reg[7] = 64'h50000;
            m_tick = '0;
            m_flag = 1'b1;
        end else begin
            if (cnt_inc) m_tick = m_tick + 63'd1;
            if (wr_en && !exp_werr(int'(wr_idx))) begin
                case (int'(wr_idx))
                    0: begin m_tick = wr_data[62:0] + 63'(cnt_inc); m_flag = wr_data[63]; end
                    2: m_reg[2] = wr_data & 64'h13DE;
                    3: m_reg[3] = wr_data & ~64'h7FFF;
                    4: m_reg[4] = {61'd0, wr_data[2:0]};
                    5: m_reg[5] = (wr_data >= NWIN) ? 64'(NWIN - 1) : wr_data;
                    12, 13, 14, 15, 16: m_trap[int'(wr_idx)-12][m_reg[4]-1] = wr_data;
                    default: m_reg[wr_idx] = wr_data;
                endcase
            end
        end
    end

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(int i, logic [63:0] d, bit inc, string req);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(i); wr_data = d; cnt_inc = inc;
        #1 chk({req, " wr_err"}, 64'(wr_err), 64'(exp_werr(i)));
        @(posedge clk);
        #1 wr_en = 1'b0; cnt_inc = 1'b0;
    endtask

    task automatic rd_chk(int i, string req);
        @(negedge clk);
        rd_idx = 6'(i);
        #1;
        chk(req, rd_data, exp_rd(i));
        chk({req, " rd_err"}, 64'(rd_err), 64'(exp_rerr(i)));
    endtask

    task automatic idle(int n, bit inc);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cnt_inc = inc;
        end
        @(negedge clk); cnt_inc = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        nbad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2: reset values on all indices
        for (int i = 0; i < 64; i++) rd_chk(i, "R2 reset");
        rd_chk(0, "R2 tick reset");
        chk("R2 tick literal", rd_data, 64'h8000_0000_0000_0000);

        // R3 processor-state mask
        wr(2, '1, 0, "R3");
        rd_chk(2, "R3 pstate");
        chk("R3 literal", rd_data, 64'h13DE);
        // R4 trap base low bits
        wr(3, '1, 0, "R4");
        rd_chk(3, "R4 tbase");
        // R7 window clamp
        wr(5, 64'd100, 0, "R7");  rd_chk(5, "R7 clamp 100");
        wr(5, 64'd8, 0, "R7");    rd_chk(5, "R7 clamp 8");
        wr(5, 64'd7, 0, "R7");    rd_chk(5, "R7 keep 7");
        wr(5, 64'd3, 0, "R7");    rd_chk(5, "R7 keep 3");
        // R6 trap access at TL 0
        wr(12, 64'hDEAD, 0, "R6 tl0");
        rd_chk(12, "R6 tl0 read");
        // R5 banking by TL-1
        wr(4, 64'd2, 0, "R5");
        wr(12, 64'hAAAA_0002, 0, "R5");
        wr(4, 64'd3, 0, "R5");
        wr(12, 64'hBBBB_0003, 0, "R5");
        wr(16, 64'hCC03, 0, "R5");
        rd_chk(12, "R5 bank3");
        wr(4, 64'd2, 0, "R5");
        rd_chk(12, "R5 bank2");
        chk("R5 bank2 literal", rd_data, 64'hAAAA_0002);
        rd_chk(16, "R5 htstate bank2");
        wr(4, 64'hF6, 0, "R5 low3");
        rd_chk(4, "R5 tl low bits");
        // R6 TL above max
        wr(4, 64'd7, 0, "R6");
        wr(13, 64'h1234, 0, "R6 tl7");
        rd_chk(13, "R6 tl7 read");
        wr(4, 64'd6, 0, "R6");
        rd_chk(13, "R6 bank6 untouched");
        // R8/R9 tick offset arithmetic
        wr(0, 64'h8000_0000_0000_0005, 1, "R8");
        rd_chk(0, "R8 tick after write");
        chk("R9 literal", rd_data, 64'h8000_0000_0000_0004);
        idle(5, 1);
        rd_chk(0, "R8 tick after 5");
        wr(0, 64'h7FFF_FFFF_FFFF_FFFE, 0, "R8 wrap");
        idle(3, 1);
        rd_chk(0, "R8 tick wrap");
        chk("R9 flag clear", 64'(rd_data[63]), 64'd0);
        // R10 floating-point status
        wr(1, 64'h40, 0, "R10");
        rd_chk(1, "R10 fp low bits");
        chk("R10 literal", rd_data, 64'h43);
        // R11 packed MMU word
        wr(6, 64'h24, 0, "R11"); wr(2, 64'hC, 0, "R11"); wr(9, 64'hC, 0, "R11");
        wr(8, 64'hA5, 0, "R11"); wr(4, 64'd3, 0, "R11");
        wr(10, 64'h1234, 0, "R11"); wr(11, 64'hBEEF, 0, "R11");
        rd_chk(17, "R11 mmu");
        chk("R11 literal", rd_data, 64'hBEEF_1234_0003_A53F);
        wr(17, 64'h0, 0, "R11 ro");
        rd_chk(17, "R11 unchanged");
        // R12 holes; R1 slots
        wr(40, 64'h55, 0, "R12"); wr(20, 64'h66, 0, "R12");
        rd_chk(40, "R12 hole read"); rd_chk(20, "R12 hole read");
        for (int i = 24; i < 40; i++) wr(i, 64'h1000 + 64'(i), 0, "R1 slot");
        for (int i = 0; i < 64; i++) rd_chk(i, "R1/R12 sweep");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int i = $urandom_range(0, 63);
            logic [63:0] d = {$urandom, $urandom};
            if (i == 4) d = 64'($urandom_range(0, 7));
            wr(i, d, 1'($urandom_range(0, 1)), "R1 random");
            rd_chk(i, "R1 random read");
            rd_chk($urandom_range(0, 63), "R12 random read");
        end
        finish_run();
    end
endmodule